// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block collects up to 32 interrupt request lines for a processor core and turns them into one request signal plus a vector number. Each line has its own trigger-type bit that selects between rising-edge capture, where the request is held in a pending flag until software clears it, and active-high level sensing, where the pending flag tracks the sampled input. Each line has an enable bit. A separate wake-enable bit can enable a line temporarily without changing its ordinary enable.

Software reaches the state through a small register port. Writes are synchronous. Reads are combinational from a shared address. The pending register is acknowledged by writing ones, which clears only the bits that are set in the written word. A read-only capability word reports the implemented line count as a compact code and carries a nonzero version field. The number of implemented lines is fixed by a parameter. When several enabled lines are pending, the lowest-numbered one wins. Its number plus a fixed base is driven out as the vector.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the pending (address 0), enable (address 1), trigger-type (address 2) and wake-enable (address 3) registers read 0, and `irq_req` and `wake_req` are 0.
- R2: A trigger-type bit of 1 makes the line rising-edge sensitive. A trigger-type bit of 0 makes it active-high level sensitive. Inputs are sampled on the clock, and a change is visible in the pending register one clock edge after it is applied.
- R3: On an edge line, a 0-to-1 input transition sets the line's pending bit. The bit stays set after the input falls, until software clears it.
- R4: Writing to address 0 clears every edge pending bit whose write-data bit is 1 and leaves bits written 0 unchanged. If a new rising edge on a line arrives in the same cycle as the clear for that line, the bit stays set.
- R5: On a level line, the pending bit is the input sampled one clock earlier. A clear write has no lasting effect while the input stays high.
- R6: The enable register at address 1 is readable and writable. Bit n set to 1 enables line n.
- R7: When any enabled line is pending, `irq_vector` equals the lowest such line number plus `VEC_BASE` (default 9). Address 5 reads that vector in bits [7:0] and `irq_req` in bit 31.
- R8: `irq_req` is 1 exactly when some line is both pending and enabled through its enable bit or its wake-enable bit.
- R9: Address 3 holds the wake-enable mask. A pending line with its wake bit set raises both `irq_req` and `wake_req` without changing the enable register. Clearing the wake bit restores the behaviour given by the enable bit alone.
- R10: Address 4 reads the capability word. Bits [2:0] hold the count code, where codes 0, 1, 2, 3, 4 and 5 mean 6, 2, 10, 16, 24 and 32 lines. Bits [15:8] hold a nonzero version (default 1). With the default code 2 the word reads 0x0102.
- R11: Bits at or above the implemented line count read 0 in the pending, enable, trigger-type and wake registers. Writes to those bits are ignored, and their inputs never raise a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | DW | Interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | VEC_W | Vector of the selected line, 0 when idle |
| wake_req | output | 1 | A wake-enabled line is pending |

## Verification
Two functions can coincide on an edge line: a software acknowledge and a fresh rising edge on the same line in the same cycle. The bench provokes this by raising the line's input in the same cycle as the write-one-to-clear of that line's pending bit. It judges the result by reading the pending register afterwards and expecting the bit to be kept. A second acknowledge, with the input held high so that no new edge arrives, must then clear the bit. This shows that the first result came from edge priority and not from a clear that was lost.

// File: rtl/vicx_pkg.sv
package vicx_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_PEND = 3'd0,
      RA_MASK = 3'd1,
      RA_TRIG = 3'd2,
      RA_WAKE = 3'd3,
      RA_CAPS = 3'd4,
      RA_VECT = 3'd5
   } reg_addr_e;

   // count code -> number of implemented lines
   function automatic int lines_for_code(int code);
      case (code)
         0: return 6;
         1: return 2;
         2: return 10;
         3: return 16;
         4: return 24;
         5: return 32;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/vicx_line.sv
module vicx_line (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_i,
   input  logic wr_bit,
   input  logic wr_pend,
   input  logic wr_mask,
   input  logic wr_trig,
   input  logic wr_wake,
   output logic pend_o,
   output logic mask_o,
   output logic trig_o,
   output logic wake_o
);
   logic samp_q, edge_q, mask_q, trig_q, wake_q;
   logic clr;

   assign clr = wr_pend & wr_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= 1'b0;
         edge_q <= 1'b0;
         mask_q <= 1'b0;
         trig_q <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         samp_q <= irq_i;
         if (wr_mask) mask_q <= wr_bit;
         if (wr_trig) trig_q <= wr_bit;
         if (wr_wake) wake_q <= wr_bit;
         // new edge has priority over an acknowledge in the same cycle
         if (!trig_q)                 edge_q <= 1'b0;
         else if (irq_i && !samp_q)   edge_q <= 1'b1;
         else if (clr)                edge_q <= 1'b0;
      end
   end

   assign pend_o = trig_q ? edge_q : samp_q;
   assign mask_o = mask_q;
   assign trig_o = trig_q;
   assign wake_o = wake_q;

   AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q && edge_q && !clr && !wr_trig) |=> pend_o) // R3
      else $error("edge pending lost without acknowledge");

   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q && irq_i && !samp_q && !wr_trig) |=> pend_o) // R4
      else $error("rising edge not captured");

   AST_LVL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_q && !wr_trig) |=> (pend_o == $past(irq_i))) // R5
      else $error("level pending does not follow input");
endmodule

// File: rtl/vicx_bank.sv
module vicx_bank
   import vicx_pkg::*;
#(
   parameter int DW     = 32,
   parameter int N_IMPL = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     irq_in,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     pend,
   output logic [DW-1:0]     mask,
   output logic [DW-1:0]     trig,
   output logic [DW-1:0]     wake
);
   logic wr_pend, wr_mask, wr_trig, wr_wake;

   assign wr_pend = reg_we && (reg_addr == RA_PEND);
   assign wr_mask = reg_we && (reg_addr == RA_MASK);
   assign wr_trig = reg_we && (reg_addr == RA_TRIG);
   assign wr_wake = reg_we && (reg_addr == RA_WAKE);

   for (genvar i = 0; i < DW; i++) begin : g_ln
      if (i < N_IMPL) begin : g_impl
         vicx_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_i   (irq_in[i]),
            .wr_bit  (reg_wdata[i]),
            .wr_pend (wr_pend),
            .wr_mask (wr_mask),
            .wr_trig (wr_trig),
            .wr_wake (wr_wake),
            .pend_o  (pend[i]),
            .mask_o  (mask[i]),
            .trig_o  (trig[i]),
            .wake_o  (wake[i])
         );
      end else begin : g_absent
         logic unused_bit;
         assign unused_bit = irq_in[i] ^ reg_wdata[i];
         assign pend[i] = 1'b0;
         assign mask[i] = 1'b0;
         assign trig[i] = 1'b0;
         assign wake[i] = 1'b0;
      end
   end
endmodule

// File: rtl/vicx_pick.sv
module vicx_pick #(
   parameter int DW = 32,
   localparam int IW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] act,
   output logic          valid,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = DW - 1; i >= 0; i--) begin
         if (act[i]) idx = IW'(i);
      end
   end
   assign valid = |act;

   AST_PICK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> act[idx]) // R7
      else $error("picked line is not active");

   AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((act & ((DW'(1) << idx) - DW'(1))) == '0)) // R7
      else $error("a lower active line was skipped");
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import vicx_pkg::*;
#(
   parameter int DW       = 32,
   parameter int CNT_CODE = 2,
   parameter int VERSION  = 1,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     irq_in,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vector,
   output logic              wake_req
);
   localparam int N_IMPL = lines_for_code(CNT_CODE);
   localparam int IW     = $clog2(DW);

   if (CNT_CODE < 0 || CNT_CODE > 5) begin : g_bad_code
      $error("CNT_CODE must be 0..5");
   end
   if (VERSION < 1 || VERSION > 255) begin : g_bad_ver
      $error("VERSION must be 1..255");
   end
   if (DW < 32 || N_IMPL > DW) begin : g_bad_dw
      $error("DW must be at least 32");
   end
   if (VEC_BASE + DW > (1 << VEC_W)) begin : g_bad_vec
      $error("vector field too narrow for VEC_BASE");
   end

   logic [DW-1:0] pend, mask, trig, wake, act;
   logic          pick_valid;
   logic [IW-1:0] pick_idx;
   logic [DW-1:0] caps_word, vect_word;

   vicx_bank #(.DW(DW), .N_IMPL(N_IMPL)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .pend      (pend),
      .mask      (mask),
      .trig      (trig),
      .wake      (wake)
   );

   assign act = pend & (mask | wake);

   vicx_pick #(.DW(DW)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .valid (pick_valid),
      .idx   (pick_idx)
   );

   assign irq_req    = pick_valid;
   assign wake_req   = |(pend & wake);
   assign irq_vector = pick_valid ? (VEC_W'(VEC_BASE) + VEC_W'(pick_idx)) : '0;

   always_comb begin
      caps_word        = '0;
      caps_word[2:0]   = 3'(CNT_CODE);
      caps_word[15:8]  = 8'(VERSION);
      vect_word        = '0;
      vect_word[VEC_W-1:0] = irq_vector;
      vect_word[DW-1]  = irq_req;
   end

   always_comb begin
      case (reg_addr)
         RA_PEND: reg_rdata = pend;
         RA_MASK: reg_rdata = mask;
         RA_TRIG: reg_rdata = trig;
         RA_WAKE: reg_rdata = wake;
         RA_CAPS: reg_rdata = caps_word;
         RA_VECT: reg_rdata = vect_word;
         default: reg_rdata = '0;
      endcase
   end

   AST_WAKE_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> irq_req) // R9
      else $error("wake request without core request");

   AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vector >= VEC_W'(VEC_BASE) &&
                   irq_vector <  VEC_W'(VEC_BASE + N_IMPL))) // R7
      else $error("vector out of implemented range");

   AST_NO_ENABLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask | wake) == '0) |-> !irq_req) // R8
      else $error("request with no line enabled");
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
   localparam int DW = 32;
   localparam int VEC_BASE = 9;
   localparam int CODE = 2;

   typedef struct {
      string       tag;
      int          kind;   // 0 rdata, 1 irq_req, 2 irq_vector, 3 wake_req
      logic [31:0] exp;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] irq_in = '0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_req;
   logic [7:0]    irq_vector;
   logic          wake_req;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 0;
   item_t q[$];
   event  ev;

   always #5 clk = ~clk;

   irq_vector_ctrl #(.DW(DW), .CNT_CODE(CODE), .VERSION(1), .VEC_W(8),
                     .VEC_BASE(VEC_BASE)) i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .irq_vector(irq_vector), .wake_req(wake_req)
   );

   function automatic int lines_exp(int code);
      int t[6] = '{6, 2, 10, 16, 24, 32};
      return t[code];
   endfunction

   // monitor: pops expected items and compares to observed outputs
   initial begin
      forever begin
         @(ev);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               0: act = reg_rdata;
               1: act = {31'd0, irq_req};
               2: act = {24'd0, irq_vector};
               default: act = {31'd0, wake_req};
            endcase
            n_checks++;
            if (act !== it.exp) begin
               n_errors++;
               $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(string tag, int kind, logic [31:0] exp);
      item_t it;
      it.tag = tag; it.kind = kind; it.exp = exp;
      q.push_back(it);
      ->ev;
      #2;
   endtask

   task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
      reg_addr = a;
      push(tag, 0, exp);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse(int line);
      @(negedge clk);
      irq_in[line] = 1'b1;
      @(negedge clk);
      irq_in[line] = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1 reset state
      rd(0, 0, "R1 pending");
      rd(1, 0, "R1 mask");
      rd(2, 0, "R1 trig");
      rd(3, 0, "R1 wake");
      push("R1 irq_req", 1, 0);
      push("R1 wake_req", 3, 0);
      // R10 capability word
      rd(4, 32'h0000_0100 | CODE, "R10 capability");
      if (lines_exp(CODE) != 10) begin
         n_errors++;
         $display("FAIL R10 bench table: actual %0d expected 10", lines_exp(CODE));
      end
      // R11 unimplemented bits
      wr(2, 32'hFFFF_FFFF);
      rd(2, 32'h0000_03FF, "R11 trig width");
      wr(1, 32'hFFFF_FFFF);
      rd(1, 32'h0000_03FF, "R11 mask width");
      wr(1, 0);
      wr(2, 32'h0000_000F);
      rd(2, 32'h0000_000F, "R2 trig readback");
      // R2/R5/R6 level line 5
      @(negedge clk); irq_in[5] = 1'b1;
      step();
      rd(0, 32'h20, "R2 level pending");
      push("R6 masked no request", 1, 0);
      wr(1, 32'h24);
      rd(1, 32'h24, "R6 mask readback");
      push("R8 request", 1, 1);
      push("R7 vector line5", 2, VEC_BASE + 5);
      rd(5, 32'h8000_0000 | (VEC_BASE + 5), "R7 vector register");
      wr(0, 32'h20);
      rd(0, 32'h20, "R5 clear while high");
      @(negedge clk); irq_in[5] = 1'b0;
      step();
      rd(0, 0, "R5 level drops");
      push("R8 no request", 1, 0);
      // R3 edge line 2
      pulse(2);
      step(); step();
      rd(0, 32'h4, "R3 edge held");
      push("R7 vector line2", 2, VEC_BASE + 2);
      @(negedge clk); irq_in[5] = 1'b1;
      step();
      rd(0, 32'h24, "R7 two pending");
      push("R7 lowest wins", 2, VEC_BASE + 2);
      wr(0, 32'h0);
      rd(0, 32'h24, "R4 zero write");
      wr(0, 32'h4);
      rd(0, 32'h20, "R4 clear edge");
      push("R7 vector after clear", 2, VEC_BASE + 5);
      @(negedge clk); irq_in[5] = 1'b0;
      step();
      rd(0, 0, "R4 all clear");
      // R4 collision: acknowledge and new edge in the same cycle
      pulse(1);
      step();
      rd(0, 32'h2, "R3 line1 pending");
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h2; irq_in[1] = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      rd(0, 32'h2, "R4 edge beats clear");
      wr(0, 32'h2);
      rd(0, 0, "R4 clear with input high");
      @(negedge clk); irq_in[1] = 1'b0;
      // R9 wake mask
      pulse(3);
      step();
      rd(0, 32'h8, "R9 line3 pending");
      push("R9 masked", 1, 0);
      wr(3, 32'h8);
      push("R9 wake raises req", 1, 1);
      push("R9 wake_req", 3, 1);
      push("R9 vector", 2, VEC_BASE + 3);
      rd(1, 32'h24, "R9 mask unchanged");
      wr(3, 0);
      push("R9 restored", 1, 0);
      push("R9 wake_req off", 3, 0);
      wr(1, 32'h8);
      push("R8 enabled pending", 1, 1);
      wr(0, 32'h8);
      push("R8 acked", 1, 0);
      // R11 inputs above implemented count
      @(negedge clk); irq_in[20] = 1'b1; irq_in[31] = 1'b1;
      wr(1, 32'hFFFF_FFFF);
      step();
      rd(0, 0, "R11 pending above count");
      push("R11 no request", 1, 0);
      wr(3, 32'hFFFF_FFFF);
      rd(3, 32'h0000_03FF, "R11 wake width");
      push("R11 no wake", 3, 0);
      step();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule